// File: doc/BRIEF.md
# RSSI-Driven Automatic Level Controller

This block closes a slow gain-control loop around a receive front end. It takes a 12-bit sample from an ADC that digitises a logarithmic power detector and drives a 6-bit step-attenuator code (0.5 dB per LSB, 0 to 31.5 dB), an enable for the low-noise amplifier and an alert flag. A free-running divider of the system clock produces one evaluation tick per period, 100 ms by default. Each tick compares the level against an upper and a lower bound and moves the attenuation by 3 dB, or switches the amplifier when the attenuation is already at an end stop.

The bounds are set in dBm and turned into ADC codes at elaboration. The detector gives 25 mV per dB above -84 dBm and the ADC LSB is 0.806 mV, so the upper bound of -15 dBm becomes code 2140, the lower bound of -50 dBm becomes 1055, and a 5 dB hysteresis becomes 155 codes. A manual override loads the attenuation and amplifier state directly. An enable input freezes the loop. The block does not drive the serial attenuator interface. It raises a one-cycle load request whenever the attenuation code changes.

Top module: `rssi_level_ctrl`

## Requirements
- R1: While reset is low, and after its release, atten_code is 0 and lna_en, alert and atten_load are 0.
- R2: On an evaluation tick with loop_en high, man_ovr low, rssi_code above 2140 and upward steps allowed, atten_code rises by 6 and saturates at 63. For example, 60 goes to 63 and never wraps.
- R3: On an evaluation tick with rssi_code below 1055 and downward steps allowed, atten_code falls by 6 and saturates at 0. For example, 3 goes to 0.
- R4: On such a tick with rssi_code below 1055, atten_code already 0 and downward steps allowed, lna_en becomes 1.
- R5: On such a tick with rssi_code above 2140, atten_code already 63 and upward steps allowed, lna_en becomes 0 and alert becomes 1.
- R6: After an upward action, downward actions stay blocked until a tick sees rssi_code at or below 1985, and that tick does not step. After a downward action, upward actions stay blocked until a tick sees rssi_code at or above 1210, and that tick does not step. A code of exactly 2140 or exactly 1055 causes no step.
- R7: alert clears one cycle after alert_clr is high. It also clears on an active tick that sees rssi_code at or below 2140. A setting tick takes priority over a clear in the same cycle.
- R8: While man_ovr is high, atten_code and lna_en take man_atten and man_lna one cycle later, and ticks have no effect. Override re-allows steps in both directions.
- R9: While loop_en is low and man_ovr is low, ticks change neither atten_code, lna_en nor alert.
- R10: atten_load is high for exactly the one cycle in which atten_code first shows a new value, and is low otherwise.
- R11: The loop evaluates at most once every TICK_CYCLES clock cycles, and exactly once in any window of TICK_CYCLES consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rssi_code | input | 12 | Detector ADC sample |
| loop_en | input | 1 | Enables automatic evaluation on ticks |
| man_ovr | input | 1 | Manual override: load man_atten and man_lna, loop suspended |
| man_atten | input | 6 | Attenuation code loaded under override |
| man_lna | input | 1 | Amplifier enable loaded under override |
| alert_clr | input | 1 | Clears the alert flag |
| atten_code | output | 6 | Attenuation code, 0.5 dB per LSB |
| lna_en | output | 1 | Low-noise amplifier enable (0 = bypassed) |
| alert | output | 1 | Set when the attenuation is exhausted and the level is still high |
| atten_load | output | 1 | One-cycle request to transfer atten_code to the attenuator |

## Verification
The assertions assume that rssi_code is steady around every tick edge, that the bounds keep the upper code above the lower one so a sample is never both too high and too low, and that TICK_CYCLES is at least 2. The bench therefore changes rssi_code only at falling edges and holds it for a full tick period. Within each period exactly one evaluation sees the value, so each table row maps to one predicted step without the bench knowing the tick phase. Override and alert-clear pulses are applied with the loop disabled, or last long enough that tick alignment cannot change the result.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int ATT_W = 6;
  localparam int ADC_W = 12;
  localparam int SLOPE_UV_PER_DB = 25000;
  localparam int INTERCEPT_DBM = -84;
  localparam int LSB_UV = 806;

  // ADC code for a detector input level in dBm, rounded to nearest
  function automatic int level_to_code(input int dbm);
    return (SLOPE_UV_PER_DB * (dbm - INTERCEPT_DBM) + LSB_UV / 2) / LSB_UV;
  endfunction

  // ADC codes spanned by a level difference in dB
  function automatic int span_to_code(input int db);
    return (SLOPE_UV_PER_DB * db + LSB_UV / 2) / LSB_UV;
  endfunction

  function automatic logic [ATT_W-1:0] att_raise(input logic [ATT_W-1:0] a, input int step);
    int s;
    s = int'(a) + step;
    if (s > (1 << ATT_W) - 1) s = (1 << ATT_W) - 1;
    return ATT_W'(s);
  endfunction

  function automatic logic [ATT_W-1:0] att_lower(input logic [ATT_W-1:0] a, input int step);
    int s;
    s = int'(a) - step;
    if (s < 0) s = 0;
    return ATT_W'(s);
  endfunction
endpackage

// File: rtl/alc_tick_gen.sv
module alc_tick_gen #(
  parameter int TICK_CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic wrap;
  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
      tick_o <= wrap;
    end
  end

  // R11: a tick never lasts two cycles
  assert_tick_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/alc_level_cmp.sv
module alc_level_cmp
  import alc_pkg::*;
#(
  parameter int UPPER_DBM = -15,
  parameter int LOWER_DBM = -50,
  parameter int HYST_DB   = 5
) (
  input  logic [ADC_W-1:0] rssi_i,
  output logic             above_hi_o,
  output logic             below_lo_o,
  output logic             rearm_up_o,
  output logic             rearm_dn_o
);
  localparam int UPPER_CODE = level_to_code(UPPER_DBM);
  localparam int LOWER_CODE = level_to_code(LOWER_DBM);
  localparam int HYST_CODE  = span_to_code(HYST_DB);

  localparam logic [ADC_W:0] UP_LIM   = (ADC_W+1)'(UPPER_CODE);
  localparam logic [ADC_W:0] LO_LIM   = (ADC_W+1)'(LOWER_CODE);
  localparam logic [ADC_W:0] DN_ARM   = (ADC_W+1)'(UPPER_CODE - HYST_CODE);
  localparam logic [ADC_W:0] UP_ARM   = (ADC_W+1)'(LOWER_CODE + HYST_CODE);

  logic [ADC_W:0] lvl;
  assign lvl = {1'b0, rssi_i};

  assign above_hi_o = lvl >  UP_LIM;
  assign below_lo_o = lvl <  LO_LIM;
  assign rearm_dn_o = lvl <= DN_ARM;
  assign rearm_up_o = lvl >= UP_ARM;

  // R6: the bounds never overlap, so one sample cannot demand both directions
  always_comb begin
    assert_bounds_disjoint_R6: assert (!(above_hi_o && below_lo_o));
  end
endmodule

// File: rtl/alc_step_ctrl.sv
module alc_step_ctrl
  import alc_pkg::*;
#(
  parameter int STEP_CODES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             loop_en_i,
  input  logic             ovr_i,
  input  logic [ATT_W-1:0] man_atten_i,
  input  logic             man_lna_i,
  input  logic             alert_clr_i,
  input  logic             above_hi_i,
  input  logic             below_lo_i,
  input  logic             rearm_up_i,
  input  logic             rearm_dn_i,
  output logic [ATT_W-1:0] atten_o,
  output logic             lna_o,
  output logic             alert_o,
  output logic             load_o
);
  localparam logic [ATT_W-1:0] ATT_MAX = '1;

  logic [ATT_W-1:0] atten_q, atten_d;
  logic lna_q, lna_d, alert_q, alert_d;
  logic arm_up_q, arm_up_d, arm_dn_q, arm_dn_d;
  logic load_q;
  logic past_valid_q;

  // named events
  logic eval_evt, up_evt, dn_evt;
  assign eval_evt = tick_i && loop_en_i && !ovr_i;
  assign up_evt   = eval_evt && above_hi_i && arm_up_q;
  assign dn_evt   = eval_evt && below_lo_i && arm_dn_q;

  always_comb begin
    atten_d  = atten_q;
    lna_d    = lna_q;
    alert_d  = alert_q;
    arm_up_d = arm_up_q;
    arm_dn_d = arm_dn_q;
    if (alert_clr_i) alert_d = 1'b0;
    if (ovr_i) begin
      atten_d  = man_atten_i;
      lna_d    = man_lna_i;
      arm_up_d = 1'b1;
      arm_dn_d = 1'b1;
    end else if (eval_evt) begin
      if (rearm_up_i) arm_up_d = 1'b1;
      if (rearm_dn_i) arm_dn_d = 1'b1;
      if (!above_hi_i) alert_d = 1'b0;
      if (up_evt) begin
        arm_dn_d = 1'b0;
        if (atten_q == ATT_MAX) begin
          lna_d   = 1'b0;
          alert_d = 1'b1;
        end else begin
          atten_d = att_raise(atten_q, STEP_CODES);
        end
      end
      if (dn_evt) begin
        arm_up_d = 1'b0;
        if (atten_q == '0) lna_d = 1'b1;
        else               atten_d = att_lower(atten_q, STEP_CODES);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      atten_q      <= '0;
      lna_q        <= 1'b0;
      alert_q      <= 1'b0;
      arm_up_q     <= 1'b1;
      arm_dn_q     <= 1'b1;
      load_q       <= 1'b0;
      past_valid_q <= 1'b0;
    end else begin
      atten_q      <= atten_d;
      lna_q        <= lna_d;
      alert_q      <= alert_d;
      arm_up_q     <= arm_up_d;
      arm_dn_q     <= arm_dn_d;
      load_q       <= (atten_d != atten_q);
      past_valid_q <= 1'b1;
    end
  end

  assign atten_o = atten_q;
  assign lna_o   = lna_q;
  assign alert_o = alert_q;
  assign load_o  = load_q;

  // R11: automatic changes only follow an enabled tick
  assert_tick_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid_q && !$past(ovr_i) && (atten_q != $past(atten_q))) |-> $past(tick_i && loop_en_i));

  // R2: an automatic rise is bounded by one step and needs a high level
  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid_q && !$past(ovr_i) && (atten_q > $past(atten_q)))
      |-> ((int'(atten_q) - int'($past(atten_q)) <= STEP_CODES) && $past(above_hi_i)));

  // R3: an automatic fall is bounded by one step and needs a low level
  assert_step_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid_q && !$past(ovr_i) && (atten_q < $past(atten_q)))
      |-> ((int'($past(atten_q)) - int'(atten_q) <= STEP_CODES) && $past(below_lo_i)));

  // R4: the loop only engages the amplifier from the bottom stop
  assert_lna_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid_q && !$past(ovr_i) && $rose(lna_q)) |-> (atten_q == '0 && $past(below_lo_i)));

  // R5: alert only rises at the top stop with the amplifier off
  assert_alert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_q) |-> (atten_q == ATT_MAX && !lna_q));

  // R6: a downward step needs the downward direction armed beforehand
  assert_hyst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid_q && !$past(ovr_i) && (atten_q < $past(atten_q))) |-> $past(arm_dn_q));
endmodule

// File: rtl/rssi_level_ctrl.sv
module rssi_level_ctrl
  import alc_pkg::*;
#(
  parameter int TICK_CYCLES = 20_000_000,
  parameter int STEP_CODES  = 6,
  parameter int UPPER_DBM   = -15,
  parameter int LOWER_DBM   = -50,
  parameter int HYST_DB     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADC_W-1:0] rssi_code,
  input  logic             loop_en,
  input  logic             man_ovr,
  input  logic [ATT_W-1:0] man_atten,
  input  logic             man_lna,
  input  logic             alert_clr,
  output logic [ATT_W-1:0] atten_code,
  output logic             lna_en,
  output logic             alert,
  output logic             atten_load
);
  logic tick;
  logic above_hi, below_lo, rearm_up, rearm_dn;
  logic past_valid_q;

  alc_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  alc_level_cmp #(
    .UPPER_DBM (UPPER_DBM),
    .LOWER_DBM (LOWER_DBM),
    .HYST_DB   (HYST_DB)
  ) u_cmp (
    .rssi_i     (rssi_code),
    .above_hi_o (above_hi),
    .below_lo_o (below_lo),
    .rearm_up_o (rearm_up),
    .rearm_dn_o (rearm_dn)
  );

  alc_step_ctrl #(.STEP_CODES(STEP_CODES)) u_step (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .loop_en_i   (loop_en),
    .ovr_i       (man_ovr),
    .man_atten_i (man_atten),
    .man_lna_i   (man_lna),
    .alert_clr_i (alert_clr),
    .above_hi_i  (above_hi),
    .below_lo_i  (below_lo),
    .rearm_up_i  (rearm_up),
    .rearm_dn_i  (rearm_dn),
    .atten_o     (atten_code),
    .lna_o       (lna_en),
    .alert_o     (alert),
    .load_o      (atten_load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) past_valid_q <= 1'b0;
    else        past_valid_q <= 1'b1;
  end

  // R10: load request marks exactly the cycles with a fresh code
  assert_load_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid_q |-> (atten_load == (atten_code != $past(atten_code))));

  // R8: override values appear one cycle later
  assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    man_ovr |=> (atten_code == $past(man_atten) && lna_en == $past(man_lna)));

  // R9: a disabled loop holds the gain state
  assert_loop_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !man_ovr) |=> ($stable(atten_code) && $stable(lna_en)));

  // R1: outputs are quiet in the cycle after reset
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (atten_code == '0 && !lna_en && !alert && !atten_load));
endmodule

// File: tb/sim_rssi_level_ctrl.sv
`timescale 1ns/1ps
module sim_rssi_level_ctrl;
  localparam int TICK = 16;
  localparam int NV = 32;
  // {rssi[11:0], atten[5:0], lna, alert} expected after one tick period
  localparam logic [19:0] VEC [NV] = '{
    {12'd1500, 6'd0,  1'b0, 1'b0},  // mid level, no action
    {12'd2141, 6'd6,  1'b0, 1'b0},  // R2 first code above bound
    {12'd2141, 6'd12, 1'b0, 1'b0},  // R2
    {12'd3000, 6'd18, 1'b0, 1'b0},  // R2
    {12'd1000, 6'd18, 1'b0, 1'b0},  // R6 blocked, rearms
    {12'd1000, 6'd12, 1'b0, 1'b0},  // R3
    {12'd2200, 6'd12, 1'b0, 1'b0},  // R6 blocked, rearms
    {12'd2200, 6'd18, 1'b0, 1'b0},  // R2
    {12'd2140, 6'd18, 1'b0, 1'b0},  // R6 exact upper code, no step
    {12'd1055, 6'd18, 1'b0, 1'b0},  // R6 exact lower code, rearms
    {12'd1054, 6'd12, 1'b0, 1'b0},  // R3
    {12'd1054, 6'd6,  1'b0, 1'b0},  // R3
    {12'd1054, 6'd0,  1'b0, 1'b0},  // R3
    {12'd1054, 6'd0,  1'b1, 1'b0},  // R4 amplifier on
    {12'd1054, 6'd0,  1'b1, 1'b0},  // R4 stays on
    {12'd1209, 6'd0,  1'b1, 1'b0},  // R6 just short of rearm
    {12'd4095, 6'd0,  1'b1, 1'b0},  // R6 blocked, rearms
    {12'd4095, 6'd6,  1'b1, 1'b0},
    {12'd4095, 6'd12, 1'b1, 1'b0},
    {12'd4095, 6'd18, 1'b1, 1'b0},
    {12'd4095, 6'd24, 1'b1, 1'b0},
    {12'd4095, 6'd30, 1'b1, 1'b0},
    {12'd4095, 6'd36, 1'b1, 1'b0},
    {12'd4095, 6'd42, 1'b1, 1'b0},
    {12'd4095, 6'd48, 1'b1, 1'b0},
    {12'd4095, 6'd54, 1'b1, 1'b0},
    {12'd4095, 6'd60, 1'b1, 1'b0},
    {12'd4095, 6'd63, 1'b1, 1'b0},  // R2 saturates at 63
    {12'd4095, 6'd63, 1'b0, 1'b1},  // R5 amplifier off, alert
    {12'd4095, 6'd63, 1'b0, 1'b1},  // R5 held
    {12'd2140, 6'd63, 1'b0, 1'b0},  // R7 cleared by level
    {12'd2141, 6'd63, 1'b0, 1'b1}   // R5 raised again
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] rssi_code = '0;
  logic loop_en = 1'b0, man_ovr = 1'b0, man_lna = 1'b0, alert_clr = 1'b0;
  logic [5:0] man_atten = '0;
  logic [5:0] atten_code;
  logic lna_en, alert, atten_load;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rssi_level_ctrl #(.TICK_CYCLES(TICK)) u0 (
    .clk(clk), .rst_n(rst_n), .rssi_code(rssi_code), .loop_en(loop_en),
    .man_ovr(man_ovr), .man_atten(man_atten), .man_lna(man_lna),
    .alert_clr(alert_clr), .atten_code(atten_code), .lna_en(lna_en),
    .alert(alert), .atten_load(atten_load)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_window(input logic [11:0] code, output int pulses);
    rssi_code = code;
    pulses = 0;
    for (int k = 0; k < TICK; k++) begin
      @(negedge clk);
      if (atten_load) pulses++;
    end
  endtask

  task automatic check_state(input string req, input int a, input int l, input int al);
    chk(req, "atten_code", int'(atten_code), a);
    chk(req, "lna_en", int'(lna_en), l);
    chk(req, "alert", int'(alert), al);
  endtask

  initial begin
    int pulses;
    int prev_att;
    repeat (3) @(negedge clk);
    check_state("R1", 0, 0, 0);
    chk("R1", "atten_load", int'(atten_load), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 0, 0, 0);
    loop_en = 1'b1;

    // table walk: one tick period per row
    prev_att = 0;
    for (int i = 0; i < NV; i++) begin
      run_window(VEC[i][19:8], pulses);
      check_state($sformatf("R2/R3/R4/R5/R6/R7 row %0d", i),
                  int'(VEC[i][7:2]), int'(VEC[i][1]), int'(VEC[i][0]));
      chk($sformatf("R10 R11 row %0d", i), "load pulses", pulses,
          (int'(VEC[i][7:2]) != prev_att) ? 1 : 0);
      prev_att = int'(VEC[i][7:2]);
    end

    // R9: loop disabled, extreme levels ignored
    loop_en = 1'b0;
    run_window(12'd0, pulses);
    check_state("R9", 63, 0, 1);
    chk("R9", "load pulses", pulses, 0);
    run_window(12'd4095, pulses);
    check_state("R9", 63, 0, 1);

    // R7: explicit clear
    alert_clr = 1'b1;
    @(negedge clk);
    alert_clr = 1'b0;
    chk("R7", "alert after clear", int'(alert), 0);

    // R8: override load, with load pulse (R10)
    man_atten = 6'd21; man_lna = 1'b1; man_ovr = 1'b1; loop_en = 1'b1;
    @(negedge clk);
    chk("R8", "atten_code", int'(atten_code), 21);
    chk("R8", "lna_en", int'(lna_en), 1);
    chk("R10", "atten_load on change", int'(atten_load), 1);
    @(negedge clk);
    chk("R10", "atten_load next cycle", int'(atten_load), 0);
    run_window(12'd4095, pulses);
    run_window(12'd4095, pulses);
    chk("R8", "atten held under override", int'(atten_code), 21);
    chk("R8", "load pulses under override", pulses, 0);

    // R2: loop resumes after override
    man_ovr = 1'b0;
    run_window(12'd4095, pulses);
    check_state("R2", 27, 1, 0);

    // R3 saturation from 3, then R4
    man_atten = 6'd3; man_lna = 1'b0; man_ovr = 1'b1;
    @(negedge clk);
    man_ovr = 1'b0;
    chk("R8", "atten_code", int'(atten_code), 3);
    run_window(12'd0, pulses);
    check_state("R3", 0, 0, 0);
    run_window(12'd0, pulses);
    check_state("R4", 0, 1, 0);

    // R1: reset in mid run
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_state("R1", 0, 0, 0);
    chk("R1", "atten_load", int'(atten_load), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule